// File: doc/BRIEF.md
# Multicore Interrupt Distributor

This block sits between a set of shared external interrupt lines and the cores of a small SMP cluster. Each line has a global enable bit and a routing mask with one bit per core. A line reaches core c when it is active, enabled, and has bit c of its mask set. Each core receives one external interrupt output, which is the OR over all lines that reach it.

Software can also hold a line active by writing to a soft-assert register. Cores send inter-processor interrupts (IPIs) by writing a cause number together with a mask of target cores. Each core holds 16 cause bits. Their OR drives that core's IPI output, and the core clears them by reading its own cause register.

The block is reached through a word-addressed external register port with separate read and write strobes. A read returns its data one cycle after the strobe. The block also holds an 8-bit IPI partition register, a read-only configuration word, a run-stall mask with one output per core, and a coherency enable bit. The address decode is a combinational classifier, `mxd_decode`. It sorts every address into one named region kind, and each storage element acts on its own kind. The block has no sequencing state beyond its registers.

Top module: `mxd_top`

## Requirements
- R1: `ext_irq_o[c]` is high when some line n has (`irq_in[n]` OR soft-assert bit n) AND enable bit n AND routing bit c of line n. The output is registered, so it follows its inputs with one clock of delay. A routing mask with several bits set delivers the line to all of those cores.
- R2: A write to 0x184 sets the enable bits that are 1 in the data. A write to 0x180 clears the enable bits that are 1 in the data. Enable bits that are 0 in the data keep their value. A read of either address returns the enables.
- R3: Routing register n is at address n, for n < NUM_IRQ. It holds NUM_CORES bits, where bit c selects core c. It resets to 1 (core 0) and reads back as written.
- R4: A write to 0x18C sets soft-assert bits. A write to 0x188 clears the selected soft-assert bits. A read of 0x188 returns the soft-assert bits.
- R5: A write to 0x140+k, for k < 16, sets cause bit k of every core c whose bit c in the data is 1. Writes to 0x150–0x17F have no effect.
- R6: A read of 0x100+p returns the 16 cause bits of core p and clears them. `ipi_irq_o[p]` is the OR of those bits and is low from the cycle after the clearing read.
- R7: Address 0x190 is an 8-bit read/write partition register. Data bits above bit 7 are dropped.
- R8: Address 0x1A0 reads the constant {version[9:0], NUM_CORES-1 [3:0], id[17:0]}, with the version in bits 31:22. Writes to it have no effect.
- R9: A write to 0x200 loads the run-stall mask, which drives `stall_o` directly. A write to 0x220 loads bit 0 into the coherency bit on `coherent_o`. Both addresses read back.
- R10: After reset the enables, soft asserts, causes, stalls, coherency and outputs are zero. `er_rdata` is the read value in the cycle after a read strobe and zero otherwise. Unmapped reads return zero. A cycle with both strobes high performs only the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| er_wr | input | 1 | Register write strobe |
| er_rd | input | 1 | Register read strobe |
| er_addr | input | 10 | Word address |
| er_wdata | input | 32 | Write data |
| er_rdata | output | 32 | Read data, one cycle after `er_rd` |
| irq_in | input | NUM_IRQ | External interrupt lines, active high |
| ext_irq_o | output | NUM_CORES | Per-core external interrupt request |
| ipi_irq_o | output | NUM_CORES | Per-core IPI request |
| stall_o | output | NUM_CORES | Per-core run-stall |
| coherent_o | output | 1 | Coherency enable |

## Verification
The following results appear one clock edge after the access that causes them:
- register state;
- IPI outputs;
- stall and coherency outputs;
- read data.

The external interrupt outputs pass through one more flop, so they appear two edges after a write to enable, soft-assert or routing, or after a change on `irq_in`. Each stimulus vector is applied for one edge, and the bench then samples read data at the next falling edge. It drops the strobes and samples the outputs at the falling edge that follows. This timing covers both latencies without relying on the order of events at an edge.

// File: rtl/mxd_pkg.sv
package mxd_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_ROUTE,
        RK_CAUSE,
        RK_IPISET,
        RK_ENCLR,
        RK_ENSET,
        RK_ASSERT,
        RK_ASSET,
        RK_PART,
        RK_CFGID,
        RK_STALL,
        RK_COHER
    } reg_kind_e;

endpackage

// File: rtl/mxd_decode.sv
module mxd_decode
    import mxd_pkg::*;
#(
    parameter int NUM_IRQ   = 8,
    parameter int NUM_CORES = 4,
    parameter int NUM_CAUSE = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind
);

    always_comb begin
        kind = RK_NONE;
        unique case (addr[9:8])
            2'b00: begin
                if (int'(addr[7:0]) < NUM_IRQ) kind = RK_ROUTE;
            end
            2'b01: begin
                if (addr[7:6] == 2'b00) begin
                    if (int'(addr[5:0]) < NUM_CORES) kind = RK_CAUSE;
                end else if (addr[7:6] == 2'b01) begin
                    if (int'(addr[5:0]) < NUM_CAUSE) kind = RK_IPISET;
                end else begin
                    unique case (addr[7:0])
                        8'h80:   kind = RK_ENCLR;
                        8'h84:   kind = RK_ENSET;
                        8'h88:   kind = RK_ASSERT;
                        8'h8C:   kind = RK_ASSET;
                        8'h90:   kind = RK_PART;
                        8'hA0:   kind = RK_CFGID;
                        default: kind = RK_NONE;
                    endcase
                end
            end
            2'b10: begin
                if (addr[7:0] == 8'h00)      kind = RK_STALL;
                else if (addr[7:0] == 8'h20) kind = RK_COHER;
            end
            default: kind = RK_NONE;
        endcase
    end

endmodule

// File: rtl/mxd_ipi_bank.sv
module mxd_ipi_bank #(
    parameter int NUM_CORES = 4,
    parameter int NUM_CAUSE = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                set_en,
    input  logic [5:0]                          set_idx,
    input  logic [NUM_CORES-1:0]                set_mask,
    input  logic                                clr_en,
    input  logic [5:0]                          clr_idx,
    output logic [NUM_CORES-1:0][NUM_CAUSE-1:0] cause_q,
    output logic [NUM_CORES-1:0]                pend_o
);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [NUM_CAUSE-1:0] bits_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q <= '0;
            end else if (clr_en && clr_idx == 6'(c)) begin
                bits_q <= '0;
            end else if (set_en && set_mask[c]) begin
                for (int k = 0; k < NUM_CAUSE; k++) begin
                    if (set_idx == 6'(k)) bits_q[k] <= 1'b1;
                end
            end
        end

        assign cause_q[c] = bits_q;
        assign pend_o[c]  = |bits_q;
    end

endmodule

// File: rtl/mxd_route.sv
module mxd_route #(
    parameter int NUM_IRQ   = 8,
    parameter int NUM_CORES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_IRQ-1:0]                active,
    input  logic [NUM_IRQ-1:0][NUM_CORES-1:0] route,
    output logic [NUM_CORES-1:0]              ext_o
);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic hit;
        logic req_q;

        always_comb begin
            hit = 1'b0;
            for (int n = 0; n < NUM_IRQ; n++) begin
                hit = hit | (active[n] & route[n][c]);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= hit;
        end

        assign ext_o[c] = req_q;
    end

endmodule

// File: rtl/mxd_top.sv
module mxd_top
    import mxd_pkg::*;
#(
    parameter int          NUM_IRQ     = 8,
    parameter int          NUM_CORES   = 4,
    parameter int          NUM_CAUSE   = 16,
    parameter logic [9:0]  CFG_VERSION = 10'h0A5,
    parameter logic [17:0] CFG_ID      = 18'h12345
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 er_wr,
    input  logic                 er_rd,
    input  logic [9:0]           er_addr,
    input  logic [31:0]          er_wdata,
    output logic [31:0]          er_rdata,
    input  logic [NUM_IRQ-1:0]   irq_in,
    output logic [NUM_CORES-1:0] ext_irq_o,
    output logic [NUM_CORES-1:0] ipi_irq_o,
    output logic [NUM_CORES-1:0] stall_o,
    output logic                 coherent_o
);

    localparam logic [31:0] CFG_WORD = {CFG_VERSION, 4'(NUM_CORES - 1), CFG_ID};
    localparam int          PART_W   = 8;

    reg_kind_e                         kind;
    logic                              rd_act;
    logic [NUM_IRQ-1:0]                enable_q;
    logic [NUM_IRQ-1:0]                soft_q;
    logic [NUM_IRQ-1:0][NUM_CORES-1:0] route_q;
    logic [PART_W-1:0]                 part_q;
    logic [NUM_CORES-1:0]              stall_q;
    logic                              coher_q;
    logic [31:0]                       rd_val;
    logic [31:0]                       rdata_q;
    logic [NUM_CORES-1:0][NUM_CAUSE-1:0] cause_q;

    assign rd_act = er_rd & ~er_wr;

    mxd_decode #(
        .NUM_IRQ  (NUM_IRQ),
        .NUM_CORES(NUM_CORES),
        .NUM_CAUSE(NUM_CAUSE)
    ) u_dec (
        .addr(er_addr),
        .kind(kind)
    );

    mxd_ipi_bank #(
        .NUM_CORES(NUM_CORES),
        .NUM_CAUSE(NUM_CAUSE)
    ) u_ipi (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (er_wr && kind == RK_IPISET),
        .set_idx (er_addr[5:0]),
        .set_mask(er_wdata[NUM_CORES-1:0]),
        .clr_en  (rd_act && kind == RK_CAUSE),
        .clr_idx (er_addr[5:0]),
        .cause_q (cause_q),
        .pend_o  (ipi_irq_o)
    );

    mxd_route #(
        .NUM_IRQ  (NUM_IRQ),
        .NUM_CORES(NUM_CORES)
    ) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .active((irq_in | soft_q) & enable_q),
        .route (route_q),
        .ext_o (ext_irq_o)
    );

    // Register writes, one storage element per region kind
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            soft_q   <= '0;
            part_q   <= '0;
            stall_q  <= '0;
            coher_q  <= 1'b0;
            for (int n = 0; n < NUM_IRQ; n++) route_q[n] <= NUM_CORES'(1);
        end else if (er_wr) begin
            unique case (kind)
                RK_ENSET:  enable_q <= enable_q | er_wdata[NUM_IRQ-1:0];
                RK_ENCLR:  enable_q <= enable_q & ~er_wdata[NUM_IRQ-1:0];
                RK_ASSET:  soft_q   <= soft_q | er_wdata[NUM_IRQ-1:0];
                RK_ASSERT: soft_q   <= soft_q & ~er_wdata[NUM_IRQ-1:0];
                RK_PART:   part_q   <= er_wdata[PART_W-1:0];
                RK_STALL:  stall_q  <= er_wdata[NUM_CORES-1:0];
                RK_COHER:  coher_q  <= er_wdata[0];
                RK_ROUTE: begin
                    for (int n = 0; n < NUM_IRQ; n++) begin
                        if (er_addr[7:0] == 8'(n)) route_q[n] <= er_wdata[NUM_CORES-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    // Read value selection
    always_comb begin
        rd_val = '0;
        unique case (kind)
            RK_ROUTE: begin
                for (int n = 0; n < NUM_IRQ; n++) begin
                    if (er_addr[7:0] == 8'(n)) rd_val = 32'(route_q[n]);
                end
            end
            RK_CAUSE: begin
                for (int p = 0; p < NUM_CORES; p++) begin
                    if (er_addr[5:0] == 6'(p)) rd_val = 32'(cause_q[p]);
                end
            end
            RK_ENCLR, RK_ENSET:  rd_val = 32'(enable_q);
            RK_ASSERT, RK_ASSET: rd_val = 32'(soft_q);
            RK_PART:             rd_val = 32'(part_q);
            RK_CFGID:            rd_val = CFG_WORD;
            RK_STALL:            rd_val = 32'(stall_q);
            RK_COHER:            rd_val = 32'(coher_q);
            default:             rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_act) rdata_q <= rd_val;
        else             rdata_q <= '0;
    end

    assign er_rdata   = rdata_q;
    assign stall_o    = stall_q;
    assign coherent_o = coher_q;

endmodule

// File: rtl/mxd_checker.sv
module mxd_checker #(
    parameter int          NUM_IRQ     = 8,
    parameter int          NUM_CORES   = 4,
    parameter logic [9:0]  CFG_VERSION = 10'h0A5,
    parameter logic [17:0] CFG_ID      = 18'h12345
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 er_wr,
    input logic                 er_rd,
    input logic [9:0]           er_addr,
    input logic [31:0]          er_wdata,
    input logic [31:0]          er_rdata,
    input logic [NUM_CORES-1:0] ext_irq_o,
    input logic [NUM_CORES-1:0] ipi_irq_o,
    input logic [NUM_CORES-1:0] stall_o
);

    localparam logic [31:0] EXP_CFG = {CFG_VERSION, 4'(NUM_CORES - 1), CFG_ID};

    // R1 / R2: clearing every enable, with no set in the next cycle, silences all cores
    assert_clear_all_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (er_wr && er_addr == 10'h180 && (&er_wdata[NUM_IRQ-1:0]))
        ##1 !(er_wr && er_addr == 10'h184) |=> ext_irq_o == '0);

    // R5: a raise makes the targeted cores' IPI outputs high
    assert_ipi_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (er_wr && er_addr[9:4] == 6'b010100)
        |=> (ipi_irq_o & $past(er_wdata[NUM_CORES-1:0])) == $past(er_wdata[NUM_CORES-1:0]));

    // R6: a clearing read drops that core's IPI output
    for (genvar p = 0; p < NUM_CORES; p++) begin : g_clr
        assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (er_rd && !er_wr && er_addr == 10'h100 + 10'(p)) |=> !ipi_irq_o[p]);
    end

    // R8: configuration word content
    assert_cfg_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (er_rd && !er_wr && er_addr == 10'h1A0) |=> er_rdata == EXP_CFG);

    // R9: stall outputs follow a stall write
    assert_stall_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (er_wr && er_addr == 10'h200) |=> stall_o == $past(er_wdata[NUM_CORES-1:0]));

    // R10: read data is zero when no read was made
    assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(er_rd && !er_wr) |=> er_rdata == '0);

endmodule

bind mxd_top mxd_checker #(
    .NUM_IRQ    (NUM_IRQ),
    .NUM_CORES  (NUM_CORES),
    .CFG_VERSION(CFG_VERSION),
    .CFG_ID     (CFG_ID)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .er_wr    (er_wr),
    .er_rd    (er_rd),
    .er_addr  (er_addr),
    .er_wdata (er_wdata),
    .er_rdata (er_rdata),
    .ext_irq_o(ext_irq_o),
    .ipi_irq_o(ipi_irq_o),
    .stall_o  (stall_o)
);

// File: tb/tb_mxd_top.sv
module tb_mxd_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        er_wr = 1'b0;
    logic        er_rd = 1'b0;
    logic [9:0]  er_addr = '0;
    logic [31:0] er_wdata = '0;
    logic [31:0] er_rdata;
    logic [7:0]  irq_in = '0;
    logic [3:0]  ext_irq_o;
    logic [3:0]  ipi_irq_o;
    logic [3:0]  stall_o;
    logic        coherent_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    mxd_top #(
        .NUM_IRQ    (8),
        .NUM_CORES  (4),
        .NUM_CAUSE  (16),
        .CFG_VERSION(10'h0A5),
        .CFG_ID     (18'h12345)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .er_wr     (er_wr),
        .er_rd     (er_rd),
        .er_addr   (er_addr),
        .er_wdata  (er_wdata),
        .er_rdata  (er_rdata),
        .irq_in    (irq_in),
        .ext_irq_o (ext_irq_o),
        .ipi_irq_o (ipi_irq_o),
        .stall_o   (stall_o),
        .coherent_o(coherent_o)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        wr;
        logic        rd;
        logic [9:0]  addr;
        logic [31:0] wd;
        logic [7:0]  irq;
        logic [31:0] exp_rd;
        logic [3:0]  exp_ext;
        logic [3:0]  exp_ipi;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{"R8 ", 1'b0, 1'b1, 10'h1A0, 32'h0,   8'h00, 32'h294D2345, 4'h0, 4'h0},
        '{"R1 ", 1'b0, 1'b0, 10'h000, 32'h0,   8'h01, 32'h0,  4'h0, 4'h0}, // line high, not enabled
        '{"R2 ", 1'b1, 1'b0, 10'h184, 32'h5,   8'h01, 32'h0,  4'h1, 4'h0},
        '{"R3 ", 1'b1, 1'b0, 10'h001, 32'h4,   8'h03, 32'h0,  4'h1, 4'h0},
        '{"R2 ", 1'b1, 1'b0, 10'h184, 32'h2,   8'h03, 32'h0,  4'h5, 4'h0},
        '{"R2 ", 1'b1, 1'b0, 10'h180, 32'h1,   8'h03, 32'h0,  4'h4, 4'h0}, // bits 1,2 kept
        '{"R2 ", 1'b0, 1'b1, 10'h184, 32'h0,   8'h03, 32'h6,  4'h4, 4'h0},
        '{"R4 ", 1'b0, 1'b1, 10'h188, 32'h0,   8'h03, 32'h0,  4'h4, 4'h0},
        '{"R4 ", 1'b1, 1'b0, 10'h18C, 32'h4,   8'h00, 32'h0,  4'h1, 4'h0},
        '{"R4 ", 1'b0, 1'b1, 10'h188, 32'h0,   8'h00, 32'h4,  4'h1, 4'h0},
        '{"R4 ", 1'b1, 1'b0, 10'h188, 32'h4,   8'h00, 32'h0,  4'h0, 4'h0},
        '{"R5 ", 1'b1, 1'b0, 10'h143, 32'hA,   8'h00, 32'h0,  4'h0, 4'hA},
        '{"R5 ", 1'b1, 1'b0, 10'h145, 32'h2,   8'h00, 32'h0,  4'h0, 4'hA},
        '{"R6 ", 1'b0, 1'b1, 10'h101, 32'h0,   8'h00, 32'h28, 4'h0, 4'h8},
        '{"R6 ", 1'b0, 1'b1, 10'h101, 32'h0,   8'h00, 32'h0,  4'h0, 4'h8},
        '{"R6 ", 1'b0, 1'b1, 10'h103, 32'h0,   8'h00, 32'h8,  4'h0, 4'h0},
        '{"R5 ", 1'b1, 1'b0, 10'h150, 32'hF,   8'h00, 32'h0,  4'h0, 4'h0}, // cause 16: no effect
        '{"R10", 1'b0, 1'b1, 10'h0FF, 32'h0,   8'h00, 32'h0,  4'h0, 4'h0},
        '{"R7 ", 1'b1, 1'b0, 10'h190, 32'h1FF, 8'h00, 32'h0,  4'h0, 4'h0},
        '{"R7 ", 1'b0, 1'b1, 10'h190, 32'h0,   8'h00, 32'hFF, 4'h0, 4'h0},
        '{"R3 ", 1'b1, 1'b0, 10'h003, 32'hF,   8'h00, 32'h0,  4'h0, 4'h0},
        '{"R1 ", 1'b1, 1'b0, 10'h184, 32'h8,   8'h08, 32'h0,  4'hF, 4'h0}, // multi-core route
        '{"R2 ", 1'b1, 1'b0, 10'h180, 32'hFF,  8'h08, 32'h0,  4'h0, 4'h0}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One access for one edge, then strobes dropped for one more edge.
    task automatic access(input logic wr, input logic rd, input logic [9:0] addr,
                          input logic [31:0] wd, output logic [31:0] rdv);
        @(negedge clk);
        er_wr = wr; er_rd = rd; er_addr = addr; er_wdata = wd;
        @(negedge clk);
        rdv = er_rdata;
        er_wr = 1'b0; er_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "ext after reset", 32'(ext_irq_o), 32'h0);
        chk("R10", "ipi after reset", 32'(ipi_irq_o), 32'h0);
        chk("R10", "stall after reset", 32'(stall_o), 32'h0);
        chk("R10", "coherent after reset", 32'(coherent_o), 32'h0);
        chk("R10", "rdata after reset", er_rdata, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 1'b1, 10'h000, 32'h0, r);
        chk("R3", "route 0 reset", r, 32'h1);
        access(1'b0, 1'b1, 10'h007, 32'h0, r);
        chk("R3", "route 7 reset", r, 32'h1);

        for (int i = 0; i < NV; i++) begin
            string t;
            t = string'(VEC[i].tag);
            @(negedge clk);
            er_wr = VEC[i].wr; er_rd = VEC[i].rd; er_addr = VEC[i].addr;
            er_wdata = VEC[i].wd; irq_in = VEC[i].irq;
            @(negedge clk);
            chk(t, $sformatf("vec %0d rdata", i), er_rdata, VEC[i].exp_rd);
            er_wr = 1'b0; er_rd = 1'b0;
            @(negedge clk);
            chk(t, $sformatf("vec %0d ext", i), 32'(ext_irq_o), 32'(VEC[i].exp_ext));
            chk(t, $sformatf("vec %0d ipi", i), 32'(ipi_irq_o), 32'(VEC[i].exp_ipi));
        end

        // R9 stall and coherency
        access(1'b1, 1'b0, 10'h200, 32'h9, r);
        chk("R9", "stall out", 32'(stall_o), 32'h9);
        access(1'b0, 1'b1, 10'h200, 32'h0, r);
        chk("R9", "stall read", r, 32'h9);
        access(1'b1, 1'b0, 10'h220, 32'h3, r);
        chk("R9", "coherent out", 32'(coherent_o), 32'h1);
        access(1'b0, 1'b1, 10'h220, 32'h0, r);
        chk("R9", "coherent read", r, 32'h1);

        // R8 write to configuration word ignored
        access(1'b1, 1'b0, 10'h1A0, 32'h0, r);
        access(1'b0, 1'b1, 10'h1A0, 32'h0, r);
        chk("R8", "cfg after write", r, 32'h294D2345);

        // R10 both strobes: write only, cause not cleared
        access(1'b1, 1'b0, 10'h140, 32'h1, r);
        chk("R5", "core0 cause0 raised", 32'(ipi_irq_o), 32'h1);
        access(1'b1, 1'b1, 10'h100, 32'h0, r);
        chk("R10", "rdata on wr+rd", r, 32'h0);
        chk("R10", "ipi kept on wr+rd", 32'(ipi_irq_o), 32'h1);
        access(1'b0, 1'b1, 10'h100, 32'h0, r);
        chk("R6", "core0 causes", r, 32'h1);
        chk("R6", "core0 ipi cleared", 32'(ipi_irq_o), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule